// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

The block turns a physical memory address into a DRAM row number and a pair of active-low chip selects. Four byte-wide boundary registers hold running totals of installed memory in 64 MB units. Each one counts its own row plus every row below it. The decoder takes address bits 33 down to 26 as a 64 MB block index. It picks the row whose range holds that index: at or above the previous row's total, and below the row's own total.

Configuration software writes the boundaries through a small byte-addressed port that sits at offsets 60h to 63h. The decoder treats a zero in the topmost register as 256, so a fully populated space has no hole at its top. Rows 0 and 1 share the first chip select, and rows 2 and 3 share the second. The result is registered, so it appears one clock after the address is presented. An address past the last boundary simply matches no row. It raises no error.

Top module: `dram_row_decoder`

## Requirements
- R1: After a synchronous active-low reset, every boundary register reads 0x00, `dec_hit` is 0, `dec_row` is 0 and `dec_cs_n` is 2'b11.
- R2: A write with `cfg_wr` high to byte offset 0x60+n (n = 0..3) stores `cfg_wdata` in boundary n. `cfg_rdata` returns the stored byte of the offset on `cfg_addr` unchanged, including 0x00 in boundary 3.
- R3: Writes to any offset outside 0x60..0x63 change no boundary register, and reading such an offset returns 0x00.
- R4: With index f = `req_addr[33:26]`, row n is selected when f is at least boundary n-1 and below boundary n. The lower bound of row 0 is 0.
- R5: Only for boundary 3, a stored value of 0x00 acts as an upper bound of 256.
- R6: A row whose boundary equals the previous boundary (or equals 0, for row 0) is never selected.
- R7: On a hit, exactly one chip select is low: `dec_cs_n[0]` for rows 0 and 1, and `dec_cs_n[1]` for rows 2 and 3.
- R8: When no row matches, including an index at or above the top boundary, `dec_hit` is 0, `dec_cs_n` is 2'b11 and `dec_row` is 0. No error is raised.
- R9: When several rows match because the boundaries are out of order, the lowest-numbered matching row is reported.
- R10: The outputs reflect the `req_vld`/`req_addr` sampled at the previous rising edge. A cycle with `req_vld` low yields the idle outputs of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the boundary registers |
| cfg_addr | input | 8 | Byte offset for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| req_vld | input | 1 | Address valid |
| req_addr | input | 34 | Physical address |
| dec_hit | output | 1 | A row matched |
| dec_row | output | 2 | Matched row number |
| dec_cs_n | output | 2 | Active-low chip selects |

## Verification
Out-of-order and overlapping boundaries are the hardest case to reach. Software never programs them on purpose, yet they are the only way to make two rows match at once. The bench loads boundary sets that run backwards, and sets where several rows are empty or where the last register is zero. For each set it sweeps all 256 values of the 64 MB index. This covers every boundary edge, every empty row, the region above the top, and the lowest-row-wins overlap. The expected result for each index comes from arithmetic on the programmed totals.

// File: rtl/rowdec_pkg.sv
// Package: shared constants and helpers for the row boundary decoder.
// Assumes boundaries are unsigned byte counts of 64 MB units.
package rowdec_pkg;
    localparam int ROWS_DEF     = 4;
    localparam int BND_W_DEF    = 8;
    localparam int ADDR_W_DEF   = 34;
    localparam int GRAN_LSB_DEF = 26;
    localparam int ROWS_PER_CS  = 2;

    // Widen a stored boundary by one bit, mapping zero to full scale when asked.
    function automatic logic [BND_W_DEF:0] widen_bound(input logic [BND_W_DEF-1:0] b,
                                                       input logic zero_is_full);
        if (zero_is_full && b == '0)
            return {1'b1, {BND_W_DEF{1'b0}}};
        return {1'b0, b};
    endfunction
endpackage

// File: rtl/rowdec_regfile.sv
// Module: rowdec_regfile
// Holds the cumulative boundary bytes behind a byte-addressed write/read port.
// Assumes REG_BASE+ROWS fits in the address width; out-of-window writes are dropped.
module rowdec_regfile #(
    parameter int ROWS     = 4,
    parameter int BND_W    = 8,
    parameter int CA_W     = 8,
    parameter int REG_BASE = 'h60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [CA_W-1:0]       addr,
    input  logic [BND_W-1:0]      wdata,
    output logic [BND_W-1:0]      rdata,
    output logic [ROWS*BND_W-1:0] bnd_flat
);
    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic [BND_W-1:0] bnd_q [ROWS];
    logic             in_win;
    logic [IDX_W-1:0] idx;
    logic [CA_W-1:0]  off;

    // Decode whether the offset falls in the register window.
    always_comb begin
        off    = addr - CA_W'(REG_BASE);
        in_win = (int'(addr) >= REG_BASE) && (int'(addr) < REG_BASE + ROWS);
        idx    = off[IDX_W-1:0];
    end

    // Store written bytes; reset clears every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) bnd_q[i] <= '0;
        end else if (wr && in_win) begin
            bnd_q[idx] <= wdata;
        end
    end

    // Return the stored byte unchanged, zero outside the window.
    always_comb begin
        rdata = in_win ? bnd_q[idx] : '0;
    end

    // Flatten the array for the matcher.
    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign bnd_flat[g*BND_W +: BND_W] = bnd_q[g];
    end
endmodule

// File: rtl/rowdec_match.sv
// Module: rowdec_match
// Compares a block index against every row's [lower, upper) range in parallel.
// Assumes the last row's zero boundary means full scale; other rows use raw values.
module rowdec_match #(
    parameter int ROWS  = 4,
    parameter int BND_W = 8
) (
    input  logic [ROWS*BND_W-1:0] bnd_flat,
    input  logic [BND_W-1:0]      field,
    output logic [ROWS-1:0]       match
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [BND_W:0] lo;
        logic [BND_W:0] hi;

        // Lower bound is the previous row's raw total, or zero for row 0.
        if (r == 0) begin : g_lo0
            assign lo = '0;
        end else begin : g_lon
            assign lo = {1'b0, bnd_flat[(r-1)*BND_W +: BND_W]};
        end

        // Upper bound is this row's total, full scale for a zero in the last row.
        if (r == ROWS - 1) begin : g_top
            assign hi = (bnd_flat[r*BND_W +: BND_W] == '0)
                        ? {1'b1, {BND_W{1'b0}}}
                        : {1'b0, bnd_flat[r*BND_W +: BND_W]};
        end else begin : g_mid
            assign hi = {1'b0, bnd_flat[r*BND_W +: BND_W]};
        end

        // Half-open range test; empty ranges never match.
        assign match[r] = ({1'b0, field} >= lo) && ({1'b0, field} < hi);
    end
endmodule

// File: rtl/rowdec_select.sv
// Module: rowdec_select
// Picks the lowest matching row and registers row, hit and folded chip selects.
// Assumes ROWS is a multiple of ROWS_PER_CS.
module rowdec_select #(
    parameter int ROWS        = 4,
    parameter int ROWS_PER_CS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vld,
    input  logic [ROWS-1:0]              match,
    output logic                         hit,
    output logic [$clog2(ROWS)-1:0]      row,
    output logic [ROWS/ROWS_PER_CS-1:0]  cs_n
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int NCS   = ROWS / ROWS_PER_CS;

    logic             any_d;
    logic [ROW_W-1:0] row_d;
    logic [NCS-1:0]   cs_n_d;

    // Priority pick: scan downward so the lowest index is written last.
    always_comb begin
        any_d = 1'b0;
        row_d = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (vld && match[i]) begin
                any_d = 1'b1;
                row_d = ROW_W'(i);
            end
        end
    end

    // Fold rows onto chip selects, active low.
    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign cs_n_d[c] = !(any_d && (int'(row_d) / ROWS_PER_CS == c));
    end

    // Register the decode result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            row  <= '0;
            cs_n <= '1;
        end else begin
            hit  <= any_d;
            row  <= row_d;
            cs_n <= cs_n_d;
        end
    end
endmodule

// File: rtl/dram_row_decoder.sv
// Module: dram_row_decoder
// Top: boundary registers, parallel range match and registered row/chip-select output.
// Assumes 64 MB granularity, so the index is req_addr[GRAN_LSB +: BND_W].
module dram_row_decoder #(
    parameter int ROWS     = rowdec_pkg::ROWS_DEF,
    parameter int BND_W    = rowdec_pkg::BND_W_DEF,
    parameter int ADDR_W   = rowdec_pkg::ADDR_W_DEF,
    parameter int GRAN_LSB = rowdec_pkg::GRAN_LSB_DEF,
    parameter int REG_BASE = 'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [BND_W-1:0]  cfg_wdata,
    output logic [BND_W-1:0]  cfg_rdata,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_hit,
    output logic [1:0]        dec_row,
    output logic [1:0]        dec_cs_n
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int NCS   = ROWS / rowdec_pkg::ROWS_PER_CS;

    logic [ROWS*BND_W-1:0] bnd_flat;
    logic [ROWS-1:0]       match;
    logic [BND_W-1:0]      field;
    logic [ROW_W-1:0]      row_q;
    logic [NCS-1:0]        cs_q;

    assign field = req_addr[GRAN_LSB +: BND_W];

    rowdec_regfile #(.ROWS(ROWS), .BND_W(BND_W), .CA_W(8), .REG_BASE(REG_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .bnd_flat(bnd_flat)
    );

    rowdec_match #(.ROWS(ROWS), .BND_W(BND_W)) u_match (
        .bnd_flat(bnd_flat), .field(field), .match(match)
    );

    rowdec_select #(.ROWS(ROWS), .ROWS_PER_CS(rowdec_pkg::ROWS_PER_CS)) u_sel (
        .clk(clk), .rst_n(rst_n), .vld(req_vld), .match(match),
        .hit(dec_hit), .row(row_q), .cs_n(cs_q)
    );

    assign dec_row  = 2'(row_q);
    assign dec_cs_n = 2'(cs_q);
endmodule

// File: rtl/dram_row_decoder_chk.sv
// Module: dram_row_decoder_chk
// Checker bound to the top; observes ports only.
module dram_row_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_vld,
    input logic       dec_hit,
    input logic [1:0] dec_row,
    input logic [1:0] dec_cs_n
);
    // R7
    cs_single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> $countones(~dec_cs_n) == 1);

    // R7
    cs_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> dec_cs_n[dec_row[1]] == 1'b0);

    // R8
    miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_cs_n == 2'b11 && dec_row == 2'd0));

    // R10
    no_req_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !dec_hit);
endmodule

bind dram_row_decoder dram_row_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .dec_hit(dec_hit), .dec_row(dec_row), .dec_cs_n(dec_cs_n)
);

// File: tb/dram_row_decoder_test.sv
module dram_row_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_vld = 1'b0;
    logic [33:0] req_addr = '0;
    logic        dec_hit;
    logic [1:0]  dec_row;
    logic [1:0]  dec_cs_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cfg_b [4];

    always #5 clk = ~clk;

    dram_row_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_vld(req_vld),
        .req_addr(req_addr), .dec_hit(dec_hit), .dec_row(dec_row), .dec_cs_n(dec_cs_n)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        @(negedge clk);
        cfg_addr = 8'(a);
        #1;
        cmp(tag, int'(cfg_rdata), exp);
    endtask

    task automatic load(input int b0, input int b1, input int b2, input int b3);
        cfg_b[0] = b0; cfg_b[1] = b1; cfg_b[2] = b2; cfg_b[3] = b3;
        for (int i = 0; i < 4; i++) wr_reg('h60 + i, cfg_b[i]);
    endtask

    // Expected decode from the cumulative-range rules (R4, R5, R6, R9).
    task automatic model(input int f, output int hit, output int row);
        hit = 0; row = 0;
        for (int r = 0; r < 4; r++) begin
            int lo = (r == 0) ? 0 : cfg_b[r-1];
            int hi = (r == 3 && cfg_b[3] == 0) ? 256 : cfg_b[r];
            if (hit == 0 && f >= lo && f < hi) begin
                hit = 1; row = r;
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int f = 0; f < 256; f++) begin
            int eh, er, ecs;
            model(f, eh, er);
            ecs = eh ? ((er < 2) ? 2 : 1) : 3;
            @(negedge clk);
            req_vld = 1'b1;
            req_addr = {8'(f), 26'(f * 40503 + 7)};
            @(negedge clk);
            req_vld = 1'b0;
            if (eh == 0) begin
                cmp("R8 hit", int'(dec_hit), 0);
                cmp("R8 cs", int'(dec_cs_n), 3);
                cmp("R8 row", int'(dec_row), 0);
            end else begin
                cmp({tag, " hit"}, int'(dec_hit), 1);
                cmp({tag, " row"}, int'(dec_row), er);
                cmp("R7 cs", int'(dec_cs_n), ecs);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) rd_chk("R1 reg", 'h60 + i, 0);
        cmp("R1 hit", int'(dec_hit), 0);
        cmp("R1 cs", int'(dec_cs_n), 3);
        cmp("R1 row", int'(dec_row), 0);

        // R2: write and readback
        load(8'h11, 8'h22, 8'h33, 8'h00);
        rd_chk("R2 reg0", 'h60, 'h11);
        rd_chk("R2 reg1", 'h61, 'h22);
        rd_chk("R2 reg2", 'h62, 'h33);
        rd_chk("R2 reg3 zero kept", 'h63, 0);

        // R3: out-of-window writes ignored
        wr_reg('h5F, 'hAA);
        wr_reg('h64, 'hBB);
        wr_reg('h00, 'hCC);
        rd_chk("R3 reg0", 'h60, 'h11);
        rd_chk("R3 reg1", 'h61, 'h22);
        rd_chk("R3 reg2", 'h62, 'h33);
        rd_chk("R3 reg3", 'h63, 0);
        rd_chk("R3 read outside", 'h5F, 0);
        rd_chk("R3 read outside", 'h64, 0);

        load(16, 32, 48, 64);        sweep("R4");
        load(10, 20, 40, 0);         sweep("R5");
        load(0, 0, 0, 0);            sweep("R5");
        load(4, 4, 12, 12);          sweep("R6");
        load(0, 9, 9, 200);          sweep("R6");
        load(10, 20, 5, 15);         sweep("R9");
        load(30, 10, 50, 5);         sweep("R9");

        // R10: result appears one clock later and clears when req_vld drops
        load(16, 32, 48, 64);
        @(negedge clk);
        req_vld = 1'b1; req_addr = {8'd40, 26'd0};
        @(negedge clk);
        req_vld = 1'b0; req_addr = {8'd5, 26'd0};
        cmp("R10 hit after one clock", int'(dec_hit), 1);
        cmp("R10 row after one clock", int'(dec_row), 2);
        @(negedge clk);
        cmp("R10 idle when not valid", int'(dec_hit), 0);
        cmp("R10 cs idle", int'(dec_cs_n), 3);

        finish_run();
    end
endmodule